// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the control-flow outcome of one jump-class instruction per clock. It takes the 8-bit opcode, the two register values, the 32-bit immediate, the signed 16-bit displacement and the current program counter, which counts 64-bit instruction slots. From these it works out whether the branch is taken and what the next program counter is. It also raises a request when the instruction is a subroutine call or a program return, and a flag when the opcode is not a legal jump. The logic is combinational and all five results are registered, so each result appears one clock after its inputs.

Two opcode classes are handled: a wide class that compares full 64-bit values and a narrow class that compares only the low 32 bits. Each comparison can be an equality test, an unsigned ordering, a signed ordering or a bit test. The second operand is either the source register or the sign-extended immediate.

Top module: `jump_resolver`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it is released, taken_o, call_o, exit_o and illegal_o are 0 and next_pc_o is 0.
- R2: Every output reflects the inputs that were present at the previous rising clock edge, which is one cycle of latency.
- R3: Opcode bits [2:0] give the class: 5 is the wide 64-bit class and 6 is the narrow 32-bit class. Bit 3 selects the second operand: 1 selects src_val_i and 0 selects the immediate. Bits [7:4] hold the condition code.
- R4: Code 0x1 is taken when the operands are equal. Code 0x5 is taken when they differ.
- R5: These codes compare unsigned: 0x2 taken when greater than, 0x3 when greater or equal, 0xA when less than, 0xB when less or equal.
- R6: These codes compare two's complement: 0x6 taken when greater than, 0x7 when greater or equal, 0xC when less than, 0xD when less or equal.
- R7: Code 0x4 is taken when the bitwise AND of the operands is nonzero.
- R8: In class 5 the immediate is sign-extended to 64 bits. In class 6 only bits [31:0] of each operand take part, and signedness is taken from bit 31.
- R9: A taken branch gives next_pc_o = pc + 1 + sign-extended offset, modulo 2^PC_W. Every other case gives pc + 1.
- R10: Code 0x0 in class 5 is always taken.
- R11: Code 0x8 in either class sets call_o. Code 0x9 in class 5 sets exit_o. Both leave taken_o at 0 and next_pc_o at pc + 1.
- R12: illegal_o is set for code 0x0 or 0x9 in class 6, for codes 0xE and 0xF, and for any class other than 5 or 6. It then forces taken_o, call_o and exit_o to 0 and next_pc_o to pc + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode_i | input | 8 | Instruction opcode |
| dst_val_i | input | DATA_W | First operand, the destination register value |
| src_val_i | input | DATA_W | Source register value |
| imm_i | input | IMM_W | Immediate field |
| off_i | input | OFF_W | Signed branch displacement, in slots |
| pc_i | input | PC_W | Current instruction slot |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | PC_W | Next instruction slot |
| call_o | output | 1 | Call request |
| exit_o | output | 1 | Return request |
| illegal_o | output | 1 | Opcode is not a legal jump |

## Verification
All five results come from a single register stage, so each one is due exactly one rising edge after the inputs that produce it. The bench drives each stimulus on a falling edge. On the next falling edge it compares every output against an expected record that a behavioural model computed when that stimulus was applied, and only then applies the following stimulus. The stimulus set contains directed corner cases: the signed/unsigned boundary, high words that differ under a narrow compare, sign extension of the immediate, and negative displacements that wrap. These are followed by several hundred randomized opcodes and operands.

// File: rtl/jr_pkg.sv
package jr_pkg;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_EQ     = 4'h1,
        JC_UGT    = 4'h2,
        JC_UGE    = 4'h3,
        JC_ANY    = 4'h4,
        JC_NE     = 4'h5,
        JC_SGT    = 4'h6,
        JC_SGE    = 4'h7,
        JC_CALL   = 4'h8,
        JC_RET    = 4'h9,
        JC_ULT    = 4'hA,
        JC_ULE    = 4'hB,
        JC_SLT    = 4'hC,
        JC_SLE    = 4'hD,
        JC_RSV_E  = 4'hE,
        JC_RSV_F  = 4'hF
    } jcode_e;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

endpackage

// File: rtl/jr_operand.sv
module jr_operand #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 32
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_reg_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] ua_o,
    output logic [DATA_W-1:0] ub_o,
    output logic [DATA_W-1:0] sa_o,
    output logic [DATA_W-1:0] sb_o
);
    localparam int IMM_EXT = DATA_W - IMM_W;
    localparam int NAR_EXT = DATA_W - NARROW_W;

    logic [DATA_W-1:0] b_full;

    always_comb begin
        if (use_reg_i) b_full = src_i;
        else           b_full = {{IMM_EXT{imm_i[IMM_W-1]}}, imm_i};
    end

    generate
        if (NAR_EXT > 0) begin : g_narrow
            always_comb begin
                if (narrow_i) begin
                    ua_o = {{NAR_EXT{1'b0}}, dst_i[NARROW_W-1:0]};
                    ub_o = {{NAR_EXT{1'b0}}, b_full[NARROW_W-1:0]};
                    sa_o = {{NAR_EXT{dst_i[NARROW_W-1]}}, dst_i[NARROW_W-1:0]};
                    sb_o = {{NAR_EXT{b_full[NARROW_W-1]}}, b_full[NARROW_W-1:0]};
                end else begin
                    ua_o = dst_i;
                    ub_o = b_full;
                    sa_o = dst_i;
                    sb_o = b_full;
                end
            end
        end else begin : g_flat
            always_comb begin
                ua_o = dst_i;
                ub_o = b_full;
                sa_o = dst_i;
                sb_o = b_full;
            end
        end
    endgenerate
endmodule

// File: rtl/jr_cond.sv
module jr_cond #(
    parameter int DATA_W = 64
) (
    input  jr_pkg::jcode_e    code_i,
    input  logic [DATA_W-1:0] ua_i,
    input  logic [DATA_W-1:0] ub_i,
    input  logic [DATA_W-1:0] sa_i,
    input  logic [DATA_W-1:0] sb_i,
    output logic              hit_o
);
    import jr_pkg::*;

    logic eq, ult, slt;

    always_comb begin
        eq  = (ua_i == ub_i);
        ult = (ua_i < ub_i);
        slt = ($signed(sa_i) < $signed(sb_i));
        unique case (code_i)
            JC_EQ:   hit_o = eq;
            JC_NE:   hit_o = !eq;
            JC_UGT:  hit_o = !ult && !eq;
            JC_UGE:  hit_o = !ult;
            JC_ULT:  hit_o = ult;
            JC_ULE:  hit_o = ult || eq;
            JC_SGT:  hit_o = !slt && !eq;
            JC_SGE:  hit_o = !slt;
            JC_SLT:  hit_o = slt;
            JC_SLE:  hit_o = slt || eq;
            JC_ANY:  hit_o = |(ua_i & ub_i);
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/jr_target.sv
module jr_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  pc_seq_o,
    output logic [PC_W-1:0]  pc_jump_o
);
    localparam int OFF_EXT = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;

    generate
        if (OFF_EXT > 0) begin : g_ext
            assign off_ext = {{OFF_EXT{off_i[OFF_W-1]}}, off_i};
        end else begin : g_trunc
            assign off_ext = off_i[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        pc_seq_o  = pc_i + PC_W'(1);
        pc_jump_o = pc_seq_o + off_ext;
    end
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 32,
    parameter int OFF_W    = 16,
    parameter int PC_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        opcode_i,
    input  logic [DATA_W-1:0] dst_val_i,
    input  logic [DATA_W-1:0] src_val_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              call_o,
    output logic              exit_o,
    output logic              illegal_o
);
    import jr_pkg::*;

    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] npc;
        logic            call;
        logic            ret;
        logic            ill;
    } res_t;

    res_t res_d, res_q;

    logic [2:0]        cls;
    jcode_e            code;
    logic              wide, narrow;
    logic [DATA_W-1:0] ua, ub, sa, sb;
    logic              hit;
    logic [PC_W-1:0]   pc_seq, pc_jump;

    assign cls    = opcode_i[2:0];
    assign code   = jcode_e'(opcode_i[7:4]);
    assign wide   = (cls == CLS_WIDE);
    assign narrow = (cls == CLS_NARROW);

    jr_operand #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .IMM_W(IMM_W)) u_opnd (
        .dst_i     (dst_val_i),
        .src_i     (src_val_i),
        .imm_i     (imm_i),
        .use_reg_i (opcode_i[3]),
        .narrow_i  (narrow),
        .ua_o      (ua),
        .ub_o      (ub),
        .sa_o      (sa),
        .sb_o      (sb)
    );

    jr_cond #(.DATA_W(DATA_W)) u_cond (
        .code_i (code),
        .ua_i   (ua),
        .ub_i   (ub),
        .sa_i   (sa),
        .sb_i   (sb),
        .hit_o  (hit)
    );

    jr_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc_i      (pc_i),
        .off_i     (off_i),
        .pc_seq_o  (pc_seq),
        .pc_jump_o (pc_jump)
    );

    always_comb begin
        res_d     = '0;
        res_d.npc = pc_seq;
        if (!(wide || narrow)) begin
            res_d.ill = 1'b1;
        end else begin
            case (code)
                JC_ALWAYS: begin
                    if (wide) res_d.taken = 1'b1;
                    else      res_d.ill   = 1'b1;
                end
                JC_CALL:  res_d.call = 1'b1;
                JC_RET: begin
                    if (wide) res_d.ret = 1'b1;
                    else      res_d.ill = 1'b1;
                end
                JC_RSV_E, JC_RSV_F: res_d.ill = 1'b1;
                default:  res_d.taken = hit;
            endcase
        end
        if (res_d.taken) res_d.npc = pc_jump;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign taken_o   = res_q.taken;
    assign next_pc_o = res_q.npc;
    assign call_o    = res_q.call;
    assign exit_o    = res_q.ret;
    assign illegal_o = res_q.ill;

    // R12
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!taken_o && !call_o && !exit_o));

    // R11
    request_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_o || exit_o) |-> (!taken_o && !(call_o && exit_o)));

    // R9
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> (next_pc_o == PC_W'($past(pc_i) + PC_W'(1))));

    // R10
    ja_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode_i[2:0]) == 3'd5 && $past(opcode_i[7:4]) == 4'h0)
        |-> taken_o);

    // R12
    narrow_ja_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode_i[2:0]) == 3'd6 && $past(opcode_i[7:4]) == 4'h0)
        |-> illegal_o);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!taken_o && !call_o && !exit_o && !illegal_o));
endmodule

// File: tb/tb_jump_resolver.sv
module tb_jump_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      opcode;
    logic [63:0]     dst, src;
    logic [31:0]     imm;
    logic [15:0]     off;
    logic [PW-1:0]   pc;
    logic            taken, call, ex, ill;
    logic [PW-1:0]   npc;

    int checks = 0;
    int failures = 0;

    logic            pend = 1'b0;
    logic            e_taken, e_call, e_exit, e_ill;
    logic [PW-1:0]   e_npc;
    string           e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    jump_resolver dut (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .dst_val_i(dst),
        .src_val_i(src), .imm_i(imm), .off_i(off), .pc_i(pc),
        .taken_o(taken), .next_pc_o(npc), .call_o(call), .exit_o(ex),
        .illegal_o(ill)
    );

    // Behavioural reference, written from the requirements.
    task automatic model(input logic [7:0] op, input logic [63:0] a,
                         input logic [63:0] s, input logic [31:0] im,
                         input logic [15:0] of, input logic [PW-1:0] p);
        int cls = int'(op[2:0]);
        int code = int'(op[7:4]);
        longint unsigned ua, ub;
        longint sa, sb;
        logic [63:0] b;
        bit t = 0;
        e_call = 0; e_exit = 0; e_ill = 0;
        b = op[3] ? s : {{32{im[31]}}, im};            // R3, R8
        if (cls == 6) begin
            ua = {32'd0, a[31:0]}; ub = {32'd0, b[31:0]};
            sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
        end else begin
            ua = a; ub = b; sa = $signed(a); sb = $signed(b);
        end
        if (cls != 5 && cls != 6) e_ill = 1;
        else if (code == 0) begin if (cls == 5) t = 1; else e_ill = 1; end
        else if (code == 8) e_call = 1;
        else if (code == 9) begin if (cls == 5) e_exit = 1; else e_ill = 1; end
        else if (code >= 14) e_ill = 1;
        else if (code == 1) t = (ua == ub);
        else if (code == 5) t = (ua != ub);
        else if (code == 2) t = (ua > ub);
        else if (code == 3) t = (ua >= ub);
        else if (code == 10) t = (ua < ub);
        else if (code == 11) t = (ua <= ub);
        else if (code == 6) t = (sa > sb);
        else if (code == 7) t = (sa >= sb);
        else if (code == 12) t = (sa < sb);
        else if (code == 13) t = (sa <= sb);
        else if (code == 4) t = ((ua & ub) != 0);
        e_taken = t;
        e_npc = t ? PW'(p + 1 + {{(PW-16){of[15]}}, of}) : PW'(p + 1);   // R9
    endtask

    function automatic string tag_of(input logic [7:0] op);
        int c = int'(op[7:4]);
        if (op[2:0] != 3'd5 && op[2:0] != 3'd6) return "R12";
        if (c == 1 || c == 5) return "R4";
        if (c == 2 || c == 3 || c == 10 || c == 11) return "R5";
        if (c == 6 || c == 7 || c == 12 || c == 13) return "R6";
        if (c == 4) return "R7";
        if (c == 0) return (op[2:0] == 3'd5) ? "R10" : "R12";
        if (c == 8) return "R11";
        if (c == 9) return (op[2:0] == 3'd5) ? "R11" : "R12";
        return "R12";
    endfunction

    // Compares the outputs due from the stimulus of the previous edge (R2).
    task automatic compare();
        checks++;
        if (taken !== e_taken || npc !== e_npc || call !== e_call ||
            ex !== e_exit || ill !== e_ill) begin
            failures++;
            $display("FAIL %s (R2 timing) actual t=%0b pc=%h c=%0b x=%0b i=%0b expected t=%0b pc=%h c=%0b x=%0b i=%0b",
                     e_tag, taken, npc, call, ex, ill, e_taken, e_npc, e_call, e_exit, e_ill);
        end
    endtask

    task automatic step(input logic [7:0] op, input logic [63:0] a, input logic [63:0] s,
                        input logic [31:0] im, input logic [15:0] of,
                        input logic [PW-1:0] p, input string tg);
        @(negedge clk);
        if (pend) compare();
        opcode = op; dst = a; src = s; imm = im; off = of; pc = p;
        model(op, a, s, im, of, p);
        e_tag = tg;
        pend = 1'b1;
    endtask

    function automatic logic [63:0] pick();
        case ($urandom_range(0, 7))
            0: return 64'd0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h0000_0000_8000_0000;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h0000_0000_7FFF_FFFF;
            5: return {32'hA5A5_0000, 32'($urandom_range(0, 3))};
            default: return {32'($urandom()), 32'($urandom())};
        endcase
    endfunction

    initial begin
        opcode = 8'h05; dst = '0; src = '0; imm = '0; off = '0; pc = 32'h100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle while in reset
        checks++;
        if (taken !== 0 || npc !== 0 || call !== 0 || ex !== 0 || ill !== 0) begin
            failures++;
            $display("FAIL R1 actual t=%0b pc=%h c=%0b x=%0b i=%0b expected all zero",
                     taken, npc, call, ex, ill);
        end
        rst_n = 1'b1;
        // R10 unconditional, negative offset wraps (R9)
        step(8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFE, 32'h0000_0010, "R10");
        step(8'h05, 64'd0, 64'd0, 32'd0, 16'hFFF0, 32'h0000_0002, "R9");
        // R4 equality, register vs immediate operand (R3)
        step(8'h1D, 64'h1234, 64'h1234, 32'd0, 16'd5, 32'h40, "R3");
        step(8'h15, 64'h1234, 64'h1234, 32'd0, 16'd5, 32'h40, "R3");
        step(8'h55, 64'h1, 64'h2, 32'd1, 16'd7, 32'h40, "R4");
        // R8 wide immediate is sign-extended
        step(8'h15, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd3, 32'h80, "R8");
        // R8 narrow compare ignores high words
        step(8'h1E, 64'hDEAD_0000_0000_0007, 64'hBEEF_0000_0000_0007, 32'd0, 16'd9, 32'h80, "R8");
        step(8'h1D, 64'hDEAD_0000_0000_0007, 64'hBEEF_0000_0000_0007, 32'd0, 16'd9, 32'h80, "R8");
        // R5 vs R6 at the sign boundary
        step(8'h2D, 64'h8000_0000_0000_0000, 64'd1, 32'd0, 16'd2, 32'h0, "R5");
        step(8'h6D, 64'h8000_0000_0000_0000, 64'd1, 32'd0, 16'd2, 32'h0, "R6");
        step(8'hCE, 64'h0000_0000_8000_0000, 64'd1, 32'd0, 16'd2, 32'h0, "R6");
        step(8'hAE, 64'h0000_0000_8000_0000, 64'd1, 32'd0, 16'd2, 32'h0, "R5");
        step(8'h3D, 64'd5, 64'd5, 32'd0, 16'd1, 32'h0, "R5");
        step(8'hBD, 64'd5, 64'd5, 32'd0, 16'd1, 32'h0, "R5");
        step(8'h7D, 64'd5, 64'd5, 32'd0, 16'd1, 32'h0, "R6");
        step(8'hDD, 64'd5, 64'd5, 32'd0, 16'd1, 32'h0, "R6");
        // R7 bit test
        step(8'h45, 64'h10, 64'd0, 32'h0000_0010, 16'd4, 32'h20, "R7");
        step(8'h4E, 64'h1_0000_0000, 64'h1_0000_0000, 32'd0, 16'd4, 32'h20, "R7");
        // R11 requests
        step(8'h85, 64'd0, 64'd0, 32'd0, 16'd100, 32'h30, "R11");
        step(8'h95, 64'd0, 64'd0, 32'd0, 16'd100, 32'h30, "R11");
        step(8'h86, 64'd0, 64'd0, 32'd0, 16'd100, 32'h30, "R11");
        // R12 illegal forms
        step(8'h06, 64'd0, 64'd0, 32'd0, 16'd8, 32'h30, "R12");
        step(8'h96, 64'd0, 64'd0, 32'd0, 16'd8, 32'h30, "R12");
        step(8'hE5, 64'd0, 64'd0, 32'd0, 16'd8, 32'h30, "R12");
        step(8'h1C, 64'd1, 64'd1, 32'd1, 16'd8, 32'h30, "R12");
        // randomized sweep
        for (int i = 0; i < 600; i++) begin
            logic [7:0] op;
            op[7:4] = 4'($urandom_range(0, 15));
            op[3]   = 1'($urandom_range(0, 1));
            op[2:0] = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7))
                    : (($urandom_range(0, 1) == 1) ? 3'd5 : 3'd6);
            step(op, pick(), pick(), 32'($urandom()), 16'($urandom()),
                 32'($urandom()), tag_of(op));
        end
        @(negedge clk);
        if (pend) compare();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule